// File: doc/BRIEF.md
# Pipelined Burst Memory Cycle Controller

This block is a synchronous word memory with a built-in four-beat burst sequencer. Each word is split into byte lanes of nine bits, four lanes by default, and the depth is a parameter kept small. On every rising clock edge the block looks at two active-low address strobes, an advance input, three chip enables and the write controls. From these it picks exactly one action: deselect, start a read, start a write, step the burst, or hold the burst at its current beat.

Writes land in the array on the edge that samples them, lane by lane. A read is sampled on one edge and its word is placed in an output register on the next edge. The word is presented on `rdata_o`. An asynchronous output enable gates `drive_o`, which is the drive enable of a tristate pad modelled as a plain data bus. The burst runs in a linear wrap-around order or in an XOR (interleaved) order, chosen by a static mode input.

The two strobes are not symmetric. The processor-side strobe is ignored completely while the primary enable is high. The controller-side strobe deselects in that case.

Top module: `pbsram_core`

## Requirements
- R1: The device counts as selected only when `en1_n` is low, `en2` is high and `en3_n` is low on the edge where a strobe is sampled. A controller strobe with `en3_n` high deselects.
- R2: A processor strobe (`pstb_n` low) while `en1_n` is high has no effect. With `cstb_n` high the ongoing burst continues or holds exactly as if no strobe were present.
- R3: A controller strobe (`cstb_n` low) with any enable inactive deselects the device.
- R4: A cycle started by the processor strobe with the device selected is a read, even when write inputs are asserted. The array is not changed.
- R5: A write is requested when `gwr_n` is low, or when `wen_n` is low with at least one `lane_n` bit low. `gwr_n` low writes all lanes whatever `wen_n` and `lane_n` are. `wen_n` low with all `lane_n` high is a read.
- R6: With `wen_n` low, `lane_n[i]` low writes only bits [9i+8:9i] of the word. All four low writes the whole word.
- R7: With both strobes high and `adv_n` low, the burst moves to the next beat. In linear mode (`ilv` low) the low two address bits are start+beat mod 4, wrapping after the fourth beat. Reads and writes both follow this order.
- R8: In interleaved mode (`ilv` high) the low two address bits are start XOR beat.
- R9: With both strobes high and `adv_n` high, the burst repeats its current address. While both strobes are high the chip enables have no effect.
- R10: A read sampled on edge N shows its word on `rdata_o` with `drive_o` high after edge N+1 and not earlier.
- R11: `drive_o` follows `oe_n` without waiting for a clock edge. `oe_n` high forces `drive_o` low.
- R12: After a deselecting edge N, `drive_o` stays high through the next cycle if a read was in flight. It falls after edge N+1.
- R13: While the inputs request a write cycle, `drive_o` is low even with `oe_n` low.
- R14: After reset the device is deselected, `rdata_o` is zero and `drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW | Word address, low two bits seed the burst |
| pstb_n | input | 1 | Processor-side address strobe, active low |
| cstb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| en1_n | input | 1 | Primary chip enable, active low |
| en2 | input | 1 | Expansion enable, active high |
| en3_n | input | 1 | Expansion enable, active low |
| gwr_n | input | 1 | Global write, all lanes, active low |
| wen_n | input | 1 | Lane write enable, active low |
| lane_n | input | LANES | Per-lane write select, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| rdata_o | output | LANES*LANE_W | Output register contents |
| drive_o | output | 1 | Pad drive enable for rdata_o |

## Verification
Bursts are run from a start beat that is not zero, so that both the wrap in linear order and the XOR order in interleaved mode show up as distinct word values. In each case the enables are pulled inactive mid-burst to show they are ignored. Writes are tried in four forms: global write, partial lane masks, the full lane mask, and an empty mask. Read-back separates a lane mix-up from a missed write or a spurious one. Strobe tests pair each enable combination with a second address that holds different data, so an ignored strobe, a deselect and a wrongly started cycle each give a different `rdata_o`/`drive_o` outcome. Timing checks sample `drive_o` one cycle early and on the expected cycle, to pin down the pipeline depth and the single-cycle deselect.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

    // One action is chosen for each clock edge
    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_DESEL,
        ACT_BEGIN_RD,
        ACT_BEGIN_WR,
        ACT_STEP,
        ACT_HOLD
    } act_e;

    // Low two address bits for a given beat of a four-beat burst
    function automatic logic [1:0] beat_low(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input logic       ilv);
        return ilv ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/pbsram_decode.sv
module pbsram_decode
    import pbsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             pstb_n,
    input  logic             cstb_n,
    input  logic             adv_n,
    input  logic             en1_n,
    input  logic             en2,
    input  logic             en3_n,
    input  logic             gwr_n,
    input  logic             wen_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             active_i,
    output act_e             act_o,
    output logic             rd_o,
    output logic             wr_o,
    output logic [LANES-1:0] lane_wr_o
);

    logic             sel;
    logic             any_wr;
    logic             cont;
    logic [LANES-1:0] lanes_req;

    always_comb begin
        sel       = ~en1_n & en2 & ~en3_n;
        any_wr    = ~gwr_n | (~wen_n & ~(&lane_n));
        lanes_req = ~gwr_n ? '1 : (~wen_n ? ~lane_n : '0);

        act_o = ACT_NONE;
        if (~pstb_n & ~en1_n) begin
            act_o = sel ? ACT_BEGIN_RD : ACT_DESEL;
        end else if (~cstb_n) begin
            act_o = sel ? (any_wr ? ACT_BEGIN_WR : ACT_BEGIN_RD) : ACT_DESEL;
        end else if (active_i) begin
            act_o = adv_n ? ACT_HOLD : ACT_STEP;
        end

        cont      = (act_o == ACT_STEP) || (act_o == ACT_HOLD);
        wr_o      = (act_o == ACT_BEGIN_WR) || (cont && any_wr);
        rd_o      = (act_o == ACT_BEGIN_RD) || (cont && ~any_wr);
        lane_wr_o = wr_o ? lanes_req : '0;
    end

endmodule

// File: rtl/pbsram_burst.sv
module pbsram_burst
    import pbsram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  act_e          act_i,
    input  logic          ilv_i,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] acc_addr_o,
    output logic          active_o
);

    localparam int BW = AW - 2;

    typedef struct packed {
        logic          active;
        logic [BW-1:0] base;
        logic [1:0]    start;
        logic [1:0]    beat;
    } burst_t;

    burst_t cur_q, cur_d;

    always_comb begin
        cur_d      = cur_q;
        acc_addr_o = {cur_q.base, beat_low(cur_q.start, cur_q.beat, ilv_i)};
        case (act_i)
            ACT_BEGIN_RD, ACT_BEGIN_WR: begin
                acc_addr_o   = addr_i;
                cur_d.active = 1'b1;
                cur_d.base   = addr_i[AW-1:2];
                cur_d.start  = addr_i[1:0];
                cur_d.beat   = 2'd0;
            end
            ACT_DESEL: cur_d.active = 1'b0;
            ACT_STEP: begin
                cur_d.beat = cur_q.beat + 2'd1;
                acc_addr_o = {cur_q.base, beat_low(cur_q.start, cur_q.beat + 2'd1, ilv_i)};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign active_o = cur_q.active;

    // R7
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_i == ACT_STEP |=> cur_q.beat == $past(cur_q.beat) + 2'd1);

    // R9
    hold_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_i == ACT_HOLD |=> $stable(cur_q.beat) && $stable(cur_q.base) && $stable(cur_q.start));

endmodule

// File: rtl/pbsram_lanes.sv
module pbsram_lanes #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int AW     = 6
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we_i,
    input  logic [AW-1:0]           addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i[g]) mem_q[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        assign rdata_o[g*LANE_W +: LANE_W] = mem_q[addr_i];
    end

endmodule

// File: rtl/pbsram_core.sv
module pbsram_core
    import pbsram_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    parameter int AW     = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr_i,
    input  logic                    pstb_n,
    input  logic                    cstb_n,
    input  logic                    adv_n,
    input  logic                    en1_n,
    input  logic                    en2,
    input  logic                    en3_n,
    input  logic                    gwr_n,
    input  logic                    wen_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic                    oe_n,
    input  logic                    ilv,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    drive_o
);

    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic              rd_pend;
        logic [WORD_W-1:0] rd_word;
        logic [WORD_W-1:0] out_word;
        logic              out_drive;
    } pipe_t;

    act_e              act;
    logic              rd_now;
    logic              wr_now;
    logic [LANES-1:0]  lane_wr;
    logic              active;
    logic [AW-1:0]     acc_addr;
    logic [WORD_W-1:0] arr_word;
    pipe_t             pipe_q, pipe_d;

    pbsram_decode #(.LANES(LANES)) u_decode (
        .pstb_n   (pstb_n),
        .cstb_n   (cstb_n),
        .adv_n    (adv_n),
        .en1_n    (en1_n),
        .en2      (en2),
        .en3_n    (en3_n),
        .gwr_n    (gwr_n),
        .wen_n    (wen_n),
        .lane_n   (lane_n),
        .active_i (active),
        .act_o    (act),
        .rd_o     (rd_now),
        .wr_o     (wr_now),
        .lane_wr_o(lane_wr)
    );

    pbsram_burst #(.AW(AW)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (act),
        .ilv_i     (ilv),
        .addr_i    (addr_i),
        .acc_addr_o(acc_addr),
        .active_o  (active)
    );

    pbsram_lanes #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_lanes (
        .clk    (clk),
        .we_i   (lane_wr),
        .addr_i (acc_addr),
        .wdata_i(wdata_i),
        .rdata_o(arr_word)
    );

    always_comb begin
        pipe_d           = pipe_q;
        pipe_d.rd_pend   = rd_now;
        if (rd_now) pipe_d.rd_word = arr_word;
        if (pipe_q.rd_pend) pipe_d.out_word = pipe_q.rd_word;
        pipe_d.out_drive = pipe_q.rd_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rdata_o = pipe_q.out_word;
    assign drive_o = pipe_q.out_drive & ~oe_n & ~wr_now;

    // R10
    read_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_now |=> ##1 pipe_q.out_drive);

    // R12
    desel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_DESEL |=> ##1 !pipe_q.out_drive);

    // R4
    proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n && !en1_n) |-> !wr_now);

    // R2
    proc_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n && en1_n && cstb_n) |-> (act == ACT_NONE || act == ACT_STEP || act == ACT_HOLD));

    // R5
    gwr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_now && !gwr_n) |-> lane_wr == '1);

endmodule

// File: tb/sim_pbsram_core.sv
module sim_pbsram_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  addr;
    logic        pstb_n, cstb_n, adv_n, en1_n, en2, en3_n;
    logic        gwr_n, wen_n, oe_n, ilv;
    logic [3:0]  lane_n;
    logic [35:0] wdata;
    logic [35:0] rdata;
    logic        drive;
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    always #5 clk = ~clk;

    pbsram_core u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .pstb_n(pstb_n), .cstb_n(cstb_n),
        .adv_n(adv_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .gwr_n(gwr_n),
        .wen_n(wen_n), .lane_n(lane_n), .wdata_i(wdata), .oe_n(oe_n), .ilv(ilv),
        .rdata_o(rdata), .drive_o(drive)
    );

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic go_idle();
        pstb_n = 1; cstb_n = 1; adv_n = 1; gwr_n = 1; wen_n = 1; lane_n = 4'hF;
        en1_n = 0; en2 = 1; en3_n = 0;
    endtask

    task automatic wr_one(input logic [5:0] a, input logic [35:0] d,
                          input logic g, input logic w, input logic [3:0] l);
        cstb_n = 0; addr = a; wdata = d; gwr_n = g; wen_n = w; lane_n = l;
        tick();
        go_idle();
    endtask

    task automatic rd_one(input logic [5:0] a, output logic [35:0] q);
        cstb_n = 0; addr = a;
        tick();
        go_idle();
        tick();
        q = rdata;
    endtask

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                          input logic [3:0] l);
        logic [35:0] r = old;
        for (int i = 0; i < 4; i++) if (!l[i]) r[i*9 +: 9] = nw[i*9 +: 9];
        return r;
    endfunction

    task automatic t_reset();
        rst_n = 0; oe_n = 0; ilv = 0; addr = 0; wdata = 0; go_idle();
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk("R14 drive after reset", {35'd0, drive}, 36'd0);
        chk("R14 output register after reset", rdata, 36'd0);
    endtask

    task automatic t_write_read();
        logic [35:0] q;
        wr_one(6'd8, 36'h123456789, 0, 1, 4'hF);
        cstb_n = 0; addr = 6'd8;
        tick();
        go_idle();
        chk("R10 drive not yet high one edge after read", {35'd0, drive}, 36'd0);
        tick();
        chk("R10 drive high two edges after read", {35'd0, drive}, 36'd1);
        chk("R10 R5 global write read back", rdata, 36'h123456789);
        wr_one(6'd9, 36'hFEDCBA987, 0, 0, 4'b0101);
        rd_one(6'd9, q);
        chk("R5 global write overrides lane selects", q, 36'hFEDCBA987);
    endtask

    task automatic t_lanes();
        logic [35:0] q, e;
        wr_one(6'd3, 36'hAAAAAAAAA, 0, 1, 4'hF);
        wr_one(6'd3, 36'h555555555, 1, 0, 4'b1010);
        e = merge(36'hAAAAAAAAA, 36'h555555555, 4'b1010);
        rd_one(6'd3, q);
        chk("R6 lanes 0 and 2 only", q, e);
        wr_one(6'd3, 36'h0F0F0F0F0, 1, 0, 4'b0111);
        e = merge(e, 36'h0F0F0F0F0, 4'b0111);
        rd_one(6'd3, q);
        chk("R6 lane 3 only", q, e);
        wr_one(6'd3, 36'h13579BDF0, 1, 0, 4'b0000);
        rd_one(6'd3, q);
        chk("R6 all lanes equal full write", q, 36'h13579BDF0);
        wr_one(6'd3, 36'hFFFFFFFFF, 1, 0, 4'b1111);
        rd_one(6'd3, q);
        chk("R5 empty lane mask writes nothing", q, 36'h13579BDF0);
    endtask

    task automatic t_proc_read();
        logic [35:0] q;
        wr_one(6'd5, 36'h0000ABCDE, 0, 1, 4'hF);
        pstb_n = 0; addr = 6'd5; gwr_n = 0; wdata = 36'h999999999;
        tick();
        go_idle();
        tick();
        chk("R4 processor start returns stored word", rdata, 36'h0000ABCDE);
        rd_one(6'd5, q);
        chk("R4 processor start left array unchanged", q, 36'h0000ABCDE);
    endtask

    task automatic t_proc_ignored();
        wr_one(6'd9, 36'h777777777, 0, 1, 4'hF);
        cstb_n = 0; addr = 6'd5;
        tick();
        go_idle();
        pstb_n = 0; en1_n = 1; addr = 6'd9;
        tick();
        go_idle();
        tick();
        chk("R2 ignored strobe keeps drive", {35'd0, drive}, 36'd1);
        chk("R2 ignored strobe keeps old address", rdata, 36'h0000ABCDE);
    endtask

    task automatic t_deselect(input string req, input logic e1, input logic e2, input logic e3);
        cstb_n = 0; addr = 6'd5;
        tick();
        go_idle();
        tick();
        cstb_n = 0; en1_n = e1; en2 = e2; en3_n = e3;
        tick();
        go_idle();
        chk({req, " R12 drive held one cycle after deselect"}, {35'd0, drive}, 36'd1);
        tick();
        chk({req, " R12 R3 drive low after deselect"}, {35'd0, drive}, 36'd0);
        tick();
        chk({req, " R3 stays deselected"}, {35'd0, drive}, 36'd0);
    endtask

    task automatic t_burst(input string req, input logic mode, input logic [5:0] start,
                           input logic [5:0] a1, input logic [5:0] a2, input logic [5:0] a3);
        for (int i = 0; i < 4; i++) wr_one(6'd16 + 6'(i), 36'h100000000 + 36'(i), 0, 1, 4'hF);
        ilv = mode;
        cstb_n = 0; addr = start;
        tick();
        go_idle();
        adv_n = 0; en1_n = 1; en2 = 0; en3_n = 1;
        tick();
        chk({req, " beat 0"}, rdata, 36'h100000000 + 36'(start - 6'd16));
        tick();
        chk({req, " beat 1"}, rdata, 36'h100000000 + 36'(a1 - 6'd16));
        tick();
        chk({req, " beat 2"}, rdata, 36'h100000000 + 36'(a2 - 6'd16));
        adv_n = 1;
        tick();
        chk({req, " beat 3"}, rdata, 36'h100000000 + 36'(a3 - 6'd16));
        tick();
        chk({req, " R9 hold repeats beat 3"}, rdata, 36'h100000000 + 36'(a3 - 6'd16));
        go_idle();
        ilv = 0;
    endtask

    task automatic t_burst_write();
        logic [35:0] q;
        cstb_n = 0; addr = 6'd5;
        tick();
        go_idle();
        tick();
        cstb_n = 0; addr = 6'd24; gwr_n = 0; wdata = 36'h0000000A0;
        #1;
        chk("R13 drive low while write requested", {35'd0, drive}, 36'd0);
        tick();
        cstb_n = 1; adv_n = 0; gwr_n = 0; wdata = 36'h0000000A1;
        tick();
        wdata = 36'h0000000A2;
        tick();
        adv_n = 1; wdata = 36'h0000000A3;
        tick();
        go_idle();
        rd_one(6'd24, q);
        chk("R7 burst write beat 0", q, 36'h0000000A0);
        rd_one(6'd25, q);
        chk("R7 burst write beat 1", q, 36'h0000000A1);
        rd_one(6'd26, q);
        chk("R9 hold write overwrote beat 2", q, 36'h0000000A3);
    endtask

    task automatic t_oe();
        oe_n = 1;
        #1;
        chk("R11 oe high floats at once", {35'd0, drive}, 36'd0);
        oe_n = 0;
        #1;
        chk("R11 oe low drives at once", {35'd0, drive}, 36'd1);
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_lanes();
        t_proc_read();
        t_proc_ignored();
        t_deselect("R3 en1", 1, 1, 0);
        t_deselect("R3 en2", 0, 0, 0);
        t_deselect("R1 en3", 0, 1, 1);
        t_burst("R7 linear", 0, 6'd18, 6'd19, 6'd16, 6'd17);
        t_burst("R8 interleaved", 1, 6'd17, 6'd16, 6'd19, 6'd18);
        t_burst_write();
        t_oe();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule